// File: doc/BRIEF.md
# Compressed Instruction Expander

This block turns one 16-bit compressed RISC-V instruction into the 32-bit base instruction that does the same work, and sets an illegal flag for reserved or unsupported encodings. It sits between instruction fetch and the main decoder. The decoder then only has to handle 32-bit words.

The expander covers all three compressed quadrants. It reassembles each scrambled immediate, maps 3-bit register fields onto x8..x15, and detects every reserved corner. The parameter `XLEN` (32, 64 or 128) decides how the width-dependent opcode slots are read:

- single- or double-precision float loads and stores;
- doubleword loads and stores;
- quadword loads and stores;
- jump-and-link versus word add-immediate.

Following the house style, the result is captured in an output register, so it appears one clock after the halfword is presented.

Top module: `cexp_top`

## Requirements
- R1: The outputs `x_insn` and `illegal` are registered. They show the expansion of `c_insn` one clock after it is sampled, and both read zero while `rst` is high.
- R2: An input with bits [1:0] = 11 sets `illegal`. Whenever `illegal` is set, `x_insn` is zero.
- R3: Quadrant 0, funct3 000 becomes `addi rd', x2, uimm`, where rd' = 8 + bits[4:2]. The immediate fields are imm[9:6] = bits[10:7], imm[5:4] = bits[12:11], imm[3] = bit 5 and imm[2] = bit 6. A zero immediate and the all-zero halfword are illegal.
- R4: Quadrant 0 loads and stores use the 3-bit register fields bits[9:7] (base) and bits[4:2] (data). The slots depend on XLEN:
  - funct3 001 and 101 are lq (opcode 0001111, funct3 010) and sq (opcode 0100011, funct3 100) when XLEN=128, and fld and fsd otherwise;
  - funct3 011 and 111 are ld and sd when XLEN≥64, and flw and fsw when XLEN=32;
  - funct3 010 and 110 are lw and sw.
- R5: Quadrant 0 funct3 100 is illegal.
- R6: Quadrant 1 funct3 101 is `jal x0`. Its offset is imm[11] = bit 12, imm[10] = bit 8, imm[9:8] = bits[10:9], imm[7] = bit 6, imm[6] = bit 7, imm[5] = bit 2, imm[4] = bit 11 and imm[3:1] = bits[5:3], sign-extended. When XLEN=32, funct3 001 is the same jump but links x1.
- R7: When XLEN≥64, quadrant 1 funct3 001 is `addiw rd, rd, simm6`, and rd = x0 is illegal.
- R8: Quadrant 1 funct3 011 depends on rd:
  - rd = x2 gives `addi x2, x2, imm`, with imm[9] = bit 12, imm[8:7] = bits[4:3], imm[6] = bit 5, imm[5] = bit 2 and imm[4] = bit 6, sign-extended;
  - any other rd gives `lui` with the sign-extended 6-bit value {bit 12, bits[6:2]} in bits [17:12] and above;
  - a zero 6-bit value is illegal in both cases.
- R9: Quadrant 1 funct3 110 and 111 become `beq` and `bne` of the register 8 + bits[9:7] against x0. The offset is imm[8] = bit 12, imm[7:6] = bits[6:5], imm[5] = bit 2, imm[4:3] = bits[11:10] and imm[2:1] = bits[4:3], sign-extended.
- R10: In quadrant 1 funct3 100, bits[11:10] select the operation as follows; register-register forms use 8 + bits[4:2] as the second source:
  - 00 is srli, 01 is srai, 10 is andi;
  - 11 is a register-register operation chosen by bit 12 and bits[6:5]. With bit 12 = 0, the values 00..11 give sub, xor, or and and. With bit 12 = 1, 00 gives subw and 01 gives addw when XLEN≥64; every other case is illegal.
- R11: The shift amount is {bit 12, bits[6:2]}. For quadrant 1 shifts and quadrant 2 funct3 000 (slli on rd), a zero amount means 64 when XLEN=128.
- R12: Quadrant 2 funct3 100 decodes as follows:
  - bit 12 = 0: rs1 = rs2 = 0 is illegal; rs2 = 0 gives `jalr x0, rs1, 0`; otherwise `addi rd, rs2, 0`;
  - bit 12 = 1: all-zero gives ebreak (0x00100073); rs2 = 0 gives `jalr x1, rs1, 0`; otherwise `add rd, rd, rs2`.
- R13: Quadrant 2 loads and stores use x2 as the base. The lwsp offset is imm[7:6] = bits[3:2], imm[5] = bit 12 and imm[4:2] = bits[6:4]. A destination of x0 is illegal for lwsp and, when XLEN≥64, for ldsp. When XLEN=32 the funct3 011 slot is flwsp, and x0 is allowed there.
- R14: Quadrant 1 funct3 000 becomes `addi rd, rd, simm6` and funct3 010 becomes `addi rd, x0, simm6`. In both, simm6 = {bit 12, bits[6:2]}, sign-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| c_insn | input | 16 | Compressed instruction halfword |
| x_insn | output | 32 | Expanded base instruction, zero when illegal |
| illegal | output | 1 | Reserved or unsupported encoding |

## Verification
The expansion logic itself has no state, so every result is due exactly one clock edge after the halfword is sampled. The bench drives `c_insn` on a falling edge, lets one rising edge capture the result, and reads both outputs at the next falling edge. Three copies of the block are driven with the same halfword, one for each XLEN, so each width-dependent slot is compared against its own expected word in the same cycle. Expected words are built in the bench from the immediate values it chose, by scattering those bits into the halfword, which is the opposite direction from the RTL.

// File: rtl/cexp_pkg.sv
package cexp_pkg;

  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_FLOAD  = 7'b0000111;
  localparam logic [6:0] OPC_QLOAD  = 7'b0001111;
  localparam logic [6:0] OPC_IMM    = 7'b0010011;
  localparam logic [6:0] OPC_IMM32  = 7'b0011011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_FSTORE = 7'b0100111;
  localparam logic [6:0] OPC_REG    = 7'b0110011;
  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_REG32  = 7'b0111011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;

  localparam logic [4:0] REG_ZERO = 5'd0;
  localparam logic [4:0] REG_LINK = 5'd1;
  localparam logic [4:0] REG_SP   = 5'd2;

  typedef struct packed {
    logic [31:0] word;
    logic        bad;
  } xres_t;

  function automatic logic [4:0] near_reg(input logic [2:0] f);
    return {2'b01, f};
  endfunction

  function automatic logic [31:0] fmt_r(input logic [6:0] f7, input logic [4:0] rs2,
                                        input logic [4:0] rs1, input logic [2:0] f3,
                                        input logic [4:0] rd, input logic [6:0] op);
    return {f7, rs2, rs1, f3, rd, op};
  endfunction

  function automatic logic [31:0] fmt_i(input logic [11:0] imm, input logic [4:0] rs1,
                                        input logic [2:0] f3, input logic [4:0] rd,
                                        input logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic logic [31:0] fmt_s(input logic [11:0] imm, input logic [4:0] rs2,
                                        input logic [4:0] rs1, input logic [2:0] f3,
                                        input logic [6:0] op);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], op};
  endfunction

  function automatic logic [31:0] fmt_b(input logic [12:0] imm, input logic [4:0] rs1,
                                        input logic [2:0] f3);
    return {imm[12], imm[10:5], REG_ZERO, rs1, f3, imm[4:1], imm[11], OPC_BRANCH};
  endfunction

  function automatic logic [31:0] fmt_u(input logic [19:0] imm, input logic [4:0] rd);
    return {imm, rd, OPC_LUI};
  endfunction

  function automatic logic [31:0] fmt_j(input logic [20:0] imm, input logic [4:0] rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, OPC_JAL};
  endfunction

  // Shift immediate: zero amount stands for 64 on the 128-bit variant
  function automatic logic [11:0] shift_imm(input logic [5:0] amt, input logic arith,
                                            input logic wide);
    logic [6:0] a7;
    a7 = {wide && (amt == 6'd0), amt};
    return {1'b0, arith, 3'b000, a7};
  endfunction

endpackage

// File: rtl/cexp_q0.sv
module cexp_q0
  import cexp_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [15:2] h,
  output xres_t       res
);
  localparam bit HAS_Q = (XLEN == 128);
  localparam bit HAS_D = (XLEN >= 64);

  logic [11:0] imm_spn, imm_w, imm_d, imm_q;
  logic [4:0]  rb, rv;

  assign imm_spn = {2'b00, h[10:7], h[12:11], h[5], h[6], 2'b00};
  assign imm_w   = {5'b0, h[5], h[12:10], h[6], 2'b00};
  assign imm_d   = {4'b0, h[6:5], h[12:10], 3'b000};
  assign imm_q   = {3'b0, h[10], h[6:5], h[12:11], 4'b0000};
  assign rb      = near_reg(h[9:7]);
  assign rv      = near_reg(h[4:2]);

  always_comb begin
    res = '{word: 32'd0, bad: 1'b0};
    unique case (h[15:13])
      3'b000: begin
        res.word = fmt_i(imm_spn, REG_SP, 3'b000, rv, OPC_IMM);
        res.bad  = (imm_spn == 12'd0);
      end
      3'b001: res.word = HAS_Q ? fmt_i(imm_q, rb, 3'b010, rv, OPC_QLOAD)
                               : fmt_i(imm_d, rb, 3'b011, rv, OPC_FLOAD);
      3'b010: res.word = fmt_i(imm_w, rb, 3'b010, rv, OPC_LOAD);
      3'b011: res.word = HAS_D ? fmt_i(imm_d, rb, 3'b011, rv, OPC_LOAD)
                               : fmt_i(imm_w, rb, 3'b010, rv, OPC_FLOAD);
      3'b100: res.bad  = 1'b1;
      3'b101: res.word = HAS_Q ? fmt_s(imm_q, rv, rb, 3'b100, OPC_STORE)
                               : fmt_s(imm_d, rv, rb, 3'b011, OPC_FSTORE);
      3'b110: res.word = fmt_s(imm_w, rv, rb, 3'b010, OPC_STORE);
      default: res.word = HAS_D ? fmt_s(imm_d, rv, rb, 3'b011, OPC_STORE)
                                : fmt_s(imm_w, rv, rb, 3'b010, OPC_FSTORE);
    endcase
  end
endmodule

// File: rtl/cexp_q1.sv
module cexp_q1
  import cexp_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [15:2] h,
  output xres_t       res
);
  localparam bit NARROW = (XLEN == 32);
  localparam bit WIDE   = (XLEN == 128);

  logic [5:0]  v6;
  logic [11:0] simm, sp_imm;
  logic [20:0] jimm;
  logic [12:0] bimm;
  logic [4:0]  rd, rp, rq;
  logic [2:0]  alu_f3;

  assign v6     = {h[12], h[6:2]};
  assign simm   = {{6{h[12]}}, v6};
  assign sp_imm = {{3{h[12]}}, h[4:3], h[5], h[2], h[6], 4'b0000};
  assign jimm   = {{10{h[12]}}, h[8], h[10:9], h[6], h[7], h[2], h[11], h[5:3], 1'b0};
  assign bimm   = {{5{h[12]}}, h[6:5], h[2], h[11:10], h[4:3], 1'b0};
  assign rd     = h[11:7];
  assign rp     = near_reg(h[9:7]);
  assign rq     = near_reg(h[4:2]);

  always_comb begin
    unique case (h[6:5])
      2'b00:   alu_f3 = 3'b000;
      2'b01:   alu_f3 = 3'b100;
      2'b10:   alu_f3 = 3'b110;
      default: alu_f3 = 3'b111;
    endcase
  end

  always_comb begin
    res = '{word: 32'd0, bad: 1'b0};
    unique case (h[15:13])
      3'b000: res.word = fmt_i(simm, rd, 3'b000, rd, OPC_IMM);
      3'b001: begin
        if (NARROW) begin
          res.word = fmt_j(jimm, REG_LINK);
        end else begin
          res.word = fmt_i(simm, rd, 3'b000, rd, OPC_IMM32);
          res.bad  = (rd == REG_ZERO);
        end
      end
      3'b010: res.word = fmt_i(simm, REG_ZERO, 3'b000, rd, OPC_IMM);
      3'b011: begin
        res.bad = (v6 == 6'd0);
        if (rd == REG_SP) res.word = fmt_i(sp_imm, REG_SP, 3'b000, REG_SP, OPC_IMM);
        else              res.word = fmt_u({{14{h[12]}}, v6}, rd);
      end
      3'b100: begin
        unique case (h[11:10])
          2'b00: res.word = fmt_i(shift_imm(v6, 1'b0, WIDE), rp, 3'b101, rp, OPC_IMM);
          2'b01: res.word = fmt_i(shift_imm(v6, 1'b1, WIDE), rp, 3'b101, rp, OPC_IMM);
          2'b10: res.word = fmt_i(simm, rp, 3'b111, rp, OPC_IMM);
          default: begin
            if (!h[12]) begin
              res.word = fmt_r((h[6:5] == 2'b00) ? 7'h20 : 7'h00, rq, rp, alu_f3, rp, OPC_REG);
            end else if (NARROW || h[6]) begin
              res.bad = 1'b1;
            end else begin
              res.word = fmt_r(h[5] ? 7'h00 : 7'h20, rq, rp, 3'b000, rp, OPC_REG32);
            end
          end
        endcase
      end
      3'b101: res.word = fmt_j(jimm, REG_ZERO);
      default: res.word = fmt_b(bimm, rp, {2'b00, h[13]});
    endcase
  end
endmodule

// File: rtl/cexp_q2.sv
module cexp_q2
  import cexp_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [15:2] h,
  output xres_t       res
);
  localparam bit HAS_Q = (XLEN == 128);
  localparam bit HAS_D = (XLEN >= 64);

  logic [11:0] ld_w, ld_d, ld_q, st_w, st_d, st_q;
  logic [4:0]  rd, rs2;
  logic        rd_zero, rs2_zero;

  assign ld_w     = {4'b0, h[3:2], h[12], h[6:4], 2'b00};
  assign ld_d     = {3'b0, h[4:2], h[12], h[6:5], 3'b000};
  assign ld_q     = {2'b0, h[5:2], h[12], h[6], 4'b0000};
  assign st_w     = {4'b0, h[8:7], h[12:9], 2'b00};
  assign st_d     = {3'b0, h[9:7], h[12:10], 3'b000};
  assign st_q     = {2'b0, h[10:7], h[12:11], 4'b0000};
  assign rd       = h[11:7];
  assign rs2      = h[6:2];
  assign rd_zero  = (rd == REG_ZERO);
  assign rs2_zero = (rs2 == REG_ZERO);

  always_comb begin
    res = '{word: 32'd0, bad: 1'b0};
    unique case (h[15:13])
      3'b000: res.word = fmt_i(shift_imm({h[12], h[6:2]}, 1'b0, HAS_Q), rd, 3'b001, rd, OPC_IMM);
      3'b001: res.word = HAS_Q ? fmt_i(ld_q, REG_SP, 3'b010, rd, OPC_QLOAD)
                               : fmt_i(ld_d, REG_SP, 3'b011, rd, OPC_FLOAD);
      3'b010: begin
        res.word = fmt_i(ld_w, REG_SP, 3'b010, rd, OPC_LOAD);
        res.bad  = rd_zero;
      end
      3'b011: begin
        if (HAS_D) begin
          res.word = fmt_i(ld_d, REG_SP, 3'b011, rd, OPC_LOAD);
          res.bad  = rd_zero;
        end else begin
          res.word = fmt_i(ld_w, REG_SP, 3'b010, rd, OPC_FLOAD);
        end
      end
      3'b100: begin
        if (!h[12]) begin
          if (rs2_zero) begin
            res.bad  = rd_zero;
            res.word = fmt_i(12'd0, rd, 3'b000, REG_ZERO, OPC_JALR);
          end else begin
            res.word = fmt_i(12'd0, rs2, 3'b000, rd, OPC_IMM);
          end
        end else begin
          if (rs2_zero && rd_zero)  res.word = 32'h0010_0073;
          else if (rs2_zero)        res.word = fmt_i(12'd0, rd, 3'b000, REG_LINK, OPC_JALR);
          else                      res.word = fmt_r(7'h00, rs2, rd, 3'b000, rd, OPC_REG);
        end
      end
      3'b101: res.word = HAS_Q ? fmt_s(st_q, rs2, REG_SP, 3'b100, OPC_STORE)
                               : fmt_s(st_d, rs2, REG_SP, 3'b011, OPC_FSTORE);
      3'b110: res.word = fmt_s(st_w, rs2, REG_SP, 3'b010, OPC_STORE);
      default: res.word = HAS_D ? fmt_s(st_d, rs2, REG_SP, 3'b011, OPC_STORE)
                                : fmt_s(st_w, rs2, REG_SP, 3'b010, OPC_FSTORE);
    endcase
  end
endmodule

// File: rtl/cexp_top.sv
module cexp_top
  import cexp_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] c_insn,
  output logic [31:0] x_insn,
  output logic        illegal
);
  localparam logic [1:0] QUAD_WIDE = 2'b11;

  xres_t r_q0, r_q1, r_q2, pick;

  cexp_q0 #(.XLEN(XLEN)) u_q0 (.h(c_insn[15:2]), .res(r_q0));
  cexp_q1 #(.XLEN(XLEN)) u_q1 (.h(c_insn[15:2]), .res(r_q1));
  cexp_q2 #(.XLEN(XLEN)) u_q2 (.h(c_insn[15:2]), .res(r_q2));

  always_comb begin
    unique case (c_insn[1:0])
      2'b00:   pick = r_q0;
      2'b01:   pick = r_q1;
      2'b10:   pick = r_q2;
      default: pick = '{word: 32'd0, bad: 1'b1};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_insn  <= 32'd0;
      illegal <= 1'b0;
    end else begin
      x_insn  <= pick.bad ? 32'd0 : pick.word;
      illegal <= pick.bad;
    end
  end

  // Set once the output register holds a real expansion
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  p_wide_input_r2: assert property (@(posedge clk) disable iff (rst)
    armed && $past(c_insn[1:0] == QUAD_WIDE) |-> illegal && (x_insn == 32'd0));

  p_legal_is_base_r2: assert property (@(posedge clk) disable iff (rst)
    armed && !illegal |-> (x_insn[1:0] == 2'b11));

  p_zero_half_r3: assert property (@(posedge clk) disable iff (rst)
    armed && $past(c_insn == 16'h0000) |-> illegal);

  p_break_word_r12: assert property (@(posedge clk) disable iff (rst)
    armed && $past(c_insn == 16'h9002) |-> (x_insn == 32'h0010_0073) && !illegal);

  p_sp_base_r13: assert property (@(posedge clk) disable iff (rst)
    armed && !illegal && $past(c_insn[1:0] == 2'b10 && c_insn[15:13] == 3'b010)
      |-> (x_insn[19:15] == REG_SP));

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) && armed == 1'b0 |-> (x_insn == 32'd0) && !illegal);
endmodule

// File: tb/tb_cexp_top.sv
`timescale 1ns/1ps
module tb_cexp_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cin = 16'h0001;
  logic [31:0] w32, w64, w128;
  logic        i32, i64, i128;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  cexp_top #(.XLEN(32))  dut32  (.clk(clk), .rst(rst), .c_insn(cin), .x_insn(w32),  .illegal(i32));
  cexp_top #(.XLEN(64))  dut    (.clk(clk), .rst(rst), .c_insn(cin), .x_insn(w64),  .illegal(i64));
  cexp_top #(.XLEN(128)) dut128 (.clk(clk), .rst(rst), .c_insn(cin), .x_insn(w128), .illegal(i128));

  function automatic logic [31:0] bi(logic [11:0] imm, logic [4:0] rs1, logic [2:0] f3,
                                     logic [4:0] rd, logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] bs(logic [11:0] imm, logic [4:0] rs2, logic [4:0] rs1,
                                     logic [2:0] f3, logic [6:0] op);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], op};
  endfunction
  function automatic logic [31:0] br(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                     logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
    return {f7, rs2, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] bj(logic [11:0] off, logic [4:0] rd);
    logic [20:0] t;
    t = {{9{off[11]}}, off};
    return {t[20], t[10:1], t[11], t[19:12], rd, 7'h6F};
  endfunction
  function automatic logic [31:0] bb(logic [8:0] off, logic [4:0] rs1, logic [2:0] f3);
    logic [12:0] t;
    t = {{4{off[8]}}, off};
    return {t[12], t[10:5], 5'd0, rs1, f3, t[4:1], t[11], 7'h63};
  endfunction
  function automatic logic [11:0] sx6(logic [5:0] v);
    return {{6{v[5]}}, v};
  endfunction

  task automatic go(input logic [15:0] c);
    @(negedge clk);
    cin = c;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int xl, input logic [31:0] ew, input logic ei);
    logic [31:0] gw;
    logic        gi;
    case (xl)
      32:      begin gw = w32;  gi = i32;  end
      64:      begin gw = w64;  gi = i64;  end
      default: begin gw = w128; gi = i128; end
    endcase
    checks++;
    if (gw !== ew || gi !== ei) begin
      fails++;
      $display("FAIL %s xlen=%0d cin=%h got word=%h ill=%b exp word=%h ill=%b",
               req, xl, cin, gw, gi, ew, ei);
    end
  endtask

  task automatic chk_all(input string req, input logic [31:0] ew, input logic ei);
    chk(req, 32, ew, ei); chk(req, 64, ew, ei); chk(req, 128, ew, ei);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk_all("R1", 32'd0, 1'b0);
  endtask

  task automatic t_wide;
    go(16'hFFFF); chk_all("R2", 32'd0, 1'b1);
    go(16'h1233); chk_all("R2", 32'd0, 1'b1);
  endtask

  task automatic t_spn;
    logic [9:0] im = 10'h104;
    go({3'b000, im[5:4], im[9:6], im[2], im[3], 3'd3, 2'b00});
    chk_all("R3", bi({2'b0, im}, 5'd2, 3'd0, 5'd11, 7'h13), 1'b0);
    go(16'h0000); chk_all("R3", 32'd0, 1'b1);
    go(16'h0014); chk_all("R3", 32'd0, 1'b1);
  endtask

  task automatic t_q0_mem;
    logic [6:0] iw = 7'h54;
    go({3'b010, iw[5:3], 3'd1, iw[2], iw[6], 3'd6, 2'b00});
    chk_all("R4", bi({5'b0, iw}, 5'd9, 3'd2, 5'd14, 7'h03), 1'b0);
    go({3'b110, iw[5:3], 3'd1, iw[2], iw[6], 3'd6, 2'b00});
    chk_all("R4", bs({5'b0, iw}, 5'd14, 5'd9, 3'd2, 7'h23), 1'b0);
    go({3'b011, 3'b101, 3'd1, 2'b11, 3'd6, 2'b00});
    chk("R4", 64,  bi(12'h0E8, 5'd9, 3'd3, 5'd14, 7'h03), 1'b0);
    chk("R4", 128, bi(12'h0E8, 5'd9, 3'd3, 5'd14, 7'h03), 1'b0);
    chk("R4", 32,  bi(12'h06C, 5'd9, 3'd2, 5'd14, 7'h07), 1'b0);
    go({3'b111, 3'b101, 3'd1, 2'b11, 3'd6, 2'b00});
    chk("R4", 64,  bs(12'h0E8, 5'd14, 5'd9, 3'd3, 7'h23), 1'b0);
    chk("R4", 128, bs(12'h0E8, 5'd14, 5'd9, 3'd3, 7'h23), 1'b0);
    chk("R4", 32,  bs(12'h06C, 5'd14, 5'd9, 3'd2, 7'h27), 1'b0);
    go({3'b001, 3'b101, 3'd1, 2'b11, 3'd6, 2'b00});
    chk("R4", 32,  bi(12'h0E8, 5'd9, 3'd3, 5'd14, 7'h07), 1'b0);
    chk("R4", 64,  bi(12'h0E8, 5'd9, 3'd3, 5'd14, 7'h07), 1'b0);
    chk("R4", 128, bi(12'h1E0, 5'd9, 3'd2, 5'd14, 7'h0F), 1'b0);
    go({3'b101, 3'b101, 3'd1, 2'b11, 3'd6, 2'b00});
    chk("R4", 32,  bs(12'h0E8, 5'd14, 5'd9, 3'd3, 7'h27), 1'b0);
    chk("R4", 64,  bs(12'h0E8, 5'd14, 5'd9, 3'd3, 7'h27), 1'b0);
    chk("R4", 128, bs(12'h1E0, 5'd14, 5'd9, 3'd4, 7'h23), 1'b0);
    go(16'h8C44); chk_all("R5", 32'd0, 1'b1);
  endtask

  task automatic t_jump;
    logic [11:0] o = 12'hA56;
    logic [11:0] p = 12'h3AA;
    go({3'b101, o[11], o[4], o[9:8], o[10], o[6], o[7], o[3:1], o[5], 2'b01});
    chk_all("R6", bj(o, 5'd0), 1'b0);
    go({3'b101, p[11], p[4], p[9:8], p[10], p[6], p[7], p[3:1], p[5], 2'b01});
    chk_all("R6", bj(p, 5'd0), 1'b0);
    go({3'b001, o[11], o[4], o[9:8], o[10], o[6], o[7], o[3:1], o[5], 2'b01});
    chk("R6", 32, bj(o, 5'd1), 1'b0);
  endtask

  task automatic t_addiw;
    logic [5:0] v = 6'h3D;
    go({3'b001, v[5], 5'd5, v[4:0], 2'b01});
    chk("R7", 64,  bi(sx6(v), 5'd5, 3'd0, 5'd5, 7'h1B), 1'b0);
    chk("R7", 128, bi(sx6(v), 5'd5, 3'd0, 5'd5, 7'h1B), 1'b0);
    go({3'b001, v[5], 5'd0, v[4:0], 2'b01});
    chk("R7", 64,  32'd0, 1'b1);
    chk("R7", 128, 32'd0, 1'b1);
  endtask

  task automatic t_small_imm;
    logic [5:0] a = 6'h21;
    logic [5:0] b = 6'h0F;
    go({3'b000, a[5], 5'd7, a[4:0], 2'b01});
    chk_all("R14", bi(sx6(a), 5'd7, 3'd0, 5'd7, 7'h13), 1'b0);
    go({3'b010, b[5], 5'd9, b[4:0], 2'b01});
    chk_all("R14", bi(sx6(b), 5'd0, 3'd0, 5'd9, 7'h13), 1'b0);
  endtask

  task automatic t_upper;
    logic [9:0] s = 10'h3D0;
    logic [5:0] v = 6'h2B;
    go({3'b011, s[9], 5'd2, s[4], s[6], s[8:7], s[5], 2'b01});
    chk_all("R8", bi({{2{s[9]}}, s}, 5'd2, 3'd0, 5'd2, 7'h13), 1'b0);
    go({3'b011, v[5], 5'd10, v[4:0], 2'b01});
    chk_all("R8", {{14{v[5]}}, v, 5'd10, 7'h37}, 1'b0);
    go({3'b011, 1'b0, 5'd10, 5'd0, 2'b01}); chk_all("R8", 32'd0, 1'b1);
    go({3'b011, 1'b0, 5'd2, 5'd0, 2'b01});  chk_all("R8", 32'd0, 1'b1);
  endtask

  task automatic t_branch;
    logic [8:0] o = 9'h1A6;
    logic [8:0] p = 9'h0CA;
    go({3'b110, o[8], o[4:3], 3'd2, o[7:6], o[2:1], o[5], 2'b01});
    chk_all("R9", bb(o, 5'd10, 3'd0), 1'b0);
    go({3'b111, p[8], p[4:3], 3'd7, p[7:6], p[2:1], p[5], 2'b01});
    chk_all("R9", bb(p, 5'd15, 3'd1), 1'b0);
  endtask

  task automatic t_alu;
    logic [5:0] v = 6'h35;
    go({3'b100, 1'b0, 2'b11, 3'd1, 2'b00, 3'd4, 2'b01});
    chk_all("R10", br(7'h20, 5'd12, 5'd9, 3'd0, 5'd9, 7'h33), 1'b0);
    go({3'b100, 1'b0, 2'b11, 3'd1, 2'b01, 3'd4, 2'b01});
    chk_all("R10", br(7'h00, 5'd12, 5'd9, 3'd4, 5'd9, 7'h33), 1'b0);
    go({3'b100, 1'b0, 2'b11, 3'd1, 2'b10, 3'd4, 2'b01});
    chk_all("R10", br(7'h00, 5'd12, 5'd9, 3'd6, 5'd9, 7'h33), 1'b0);
    go({3'b100, 1'b0, 2'b11, 3'd1, 2'b11, 3'd4, 2'b01});
    chk_all("R10", br(7'h00, 5'd12, 5'd9, 3'd7, 5'd9, 7'h33), 1'b0);
    go({3'b100, 1'b1, 2'b11, 3'd1, 2'b00, 3'd4, 2'b01});
    chk("R10", 64, br(7'h20, 5'd12, 5'd9, 3'd0, 5'd9, 7'h3B), 1'b0);
    chk("R10", 32, 32'd0, 1'b1);
    go({3'b100, 1'b1, 2'b11, 3'd1, 2'b01, 3'd4, 2'b01});
    chk("R10", 128, br(7'h00, 5'd12, 5'd9, 3'd0, 5'd9, 7'h3B), 1'b0);
    go({3'b100, 1'b1, 2'b11, 3'd1, 2'b10, 3'd4, 2'b01});
    chk_all("R10", 32'd0, 1'b1);
    go({3'b100, v[5], 2'b10, 3'd1, v[4:0], 2'b01});
    chk_all("R10", bi(sx6(v), 5'd9, 3'd7, 5'd9, 7'h13), 1'b0);
  endtask

  task automatic t_shift;
    go({3'b100, 1'b1, 2'b00, 3'd1, 5'b00101, 2'b01});
    chk("R11", 64,  bi(12'h025, 5'd9, 3'd5, 5'd9, 7'h13), 1'b0);
    chk("R11", 128, bi(12'h025, 5'd9, 3'd5, 5'd9, 7'h13), 1'b0);
    go({3'b100, 1'b0, 2'b01, 3'd1, 5'b00111, 2'b01});
    chk_all("R11", bi(12'h407, 5'd9, 3'd5, 5'd9, 7'h13), 1'b0);
    go({3'b100, 1'b0, 2'b00, 3'd1, 5'b00000, 2'b01});
    chk("R11", 64,  bi(12'h000, 5'd9, 3'd5, 5'd9, 7'h13), 1'b0);
    chk("R11", 128, bi(12'h040, 5'd9, 3'd5, 5'd9, 7'h13), 1'b0);
    go({3'b000, 1'b0, 5'd13, 5'b01011, 2'b10});
    chk_all("R11", bi(12'h00B, 5'd13, 3'd1, 5'd13, 7'h13), 1'b0);
    go({3'b000, 1'b0, 5'd13, 5'b00000, 2'b10});
    chk("R11", 128, bi(12'h040, 5'd13, 3'd1, 5'd13, 7'h13), 1'b0);
  endtask

  task automatic t_q2_reg;
    go(16'h8002); chk_all("R12", 32'd0, 1'b1);
    go({3'b100, 1'b0, 5'd6, 5'd0, 2'b10});
    chk_all("R12", bi(12'd0, 5'd6, 3'd0, 5'd0, 7'h67), 1'b0);
    go({3'b100, 1'b0, 5'd8, 5'd11, 2'b10});
    chk_all("R12", bi(12'd0, 5'd11, 3'd0, 5'd8, 7'h13), 1'b0);
    go(16'h9002); chk_all("R12", 32'h0010_0073, 1'b0);
    go({3'b100, 1'b1, 5'd7, 5'd0, 2'b10});
    chk_all("R12", bi(12'd0, 5'd7, 3'd0, 5'd1, 7'h67), 1'b0);
    go({3'b100, 1'b1, 5'd8, 5'd11, 2'b10});
    chk_all("R12", br(7'h00, 5'd11, 5'd8, 3'd0, 5'd8, 7'h33), 1'b0);
  endtask

  task automatic t_sp_mem;
    logic [7:0] w = 8'hB4;
    go({3'b010, w[5], 5'd12, w[4:2], w[7:6], 2'b10});
    chk_all("R13", bi({4'b0, w}, 5'd2, 3'd2, 5'd12, 7'h03), 1'b0);
    go({3'b010, w[5], 5'd0, w[4:2], w[7:6], 2'b10});
    chk_all("R13", 32'd0, 1'b1);
    go({3'b011, 1'b1, 5'd12, 2'b01, 3'b110, 2'b10});
    chk("R13", 64,  bi(12'h1A8, 5'd2, 3'd3, 5'd12, 7'h03), 1'b0);
    chk("R13", 128, bi(12'h1A8, 5'd2, 3'd3, 5'd12, 7'h03), 1'b0);
    chk("R13", 32,  bi(12'h0AC, 5'd2, 3'd2, 5'd12, 7'h07), 1'b0);
    go({3'b011, 1'b1, 5'd0, 2'b01, 3'b110, 2'b10});
    chk("R13", 64,  32'd0, 1'b1);
    chk("R13", 128, 32'd0, 1'b1);
    chk("R13", 32,  bi(12'h0AC, 5'd2, 3'd2, 5'd0, 7'h07), 1'b0);
    go({3'b110, w[5:2], w[7:6], 5'd15, 2'b10});
    chk_all("R13", bs({4'b0, w}, 5'd15, 5'd2, 3'd2, 7'h23), 1'b0);
    go({3'b111, 3'b101, 3'b110, 5'd15, 2'b10});
    chk("R13", 64, bs(12'h1A8, 5'd15, 5'd2, 3'd3, 7'h23), 1'b0);
    chk("R13", 32, bs(12'h0AC, 5'd15, 5'd2, 3'd2, 7'h27), 1'b0);
    go({3'b001, 1'b1, 5'd12, 5'b11011, 2'b10});
    chk("R13", 64,  bi(12'h0F8, 5'd2, 3'd3, 5'd12, 7'h07), 1'b0);
    chk("R13", 128, bi(12'h2F0, 5'd2, 3'd2, 5'd12, 7'h0F), 1'b0);
    go({3'b101, 6'b101101, 5'd15, 2'b10});
    chk("R13", 32,  bs(12'h168, 5'd15, 5'd2, 3'd3, 7'h27), 1'b0);
    chk("R13", 128, bs(12'h360, 5'd15, 5'd2, 3'd4, 7'h23), 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_wide();
    t_spn();
    t_q0_mem();
    t_jump();
    t_addiw();
    t_small_imm();
    t_upper();
    t_branch();
    t_alu();
    t_shift();
    t_q2_reg();
    t_sp_mem();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule